// File: doc/BRIEF.md
# Packet-Number Replay Guard

This block protects one receive session against replayed frames. Each received frame brings a packet number (PN), and the block checks that it is strictly larger than the last PN it accepted. The check can cover a 24-bit, 48-bit or 128-bit PN. An optional parity rule can require every accepted PN to be even, or every accepted PN to be odd. The block keeps the last accepted PN and a flag that says that PN is valid. When the valid flag is clear, the first frame seeds the stored PN without any check. Software can also preload the stored PN directly.

A failing frame can set a sticky error flag. Only software can clear it. While the flag is set, every frame is sent to the exception path as a bypass: the block does not check it and does not learn from it.

Each frame arrives as a single-cycle strobe with its PN. The verdict comes back one cycle later on `res_valid`, together with exactly one of the pass, fail and bypass indications. Decrypting the frame and extracting the PN from its header happen upstream of this block.

Top module: `pn_replay_guard`

## Requirements
- R1: After reset, `res_valid`, `res_pass`, `res_fail`, `res_bypass`, `err_sticky` and `pn_valid` are 0, and `pn_stored` is all zeros.
- R2: While `pn_valid` is 0 and no error is held, a frame passes regardless of any check control. Its PN is stored and `pn_valid` becomes 1.
- R3: When `cfg_check_en` is 0 and a PN is held, every non-bypassed frame passes, and its full PN becomes the stored PN.
- R4: When checking is enabled and a PN is held, a frame passes only if its PN, restricted to the active width, is strictly greater than the stored PN restricted to the same width. An equal PN fails.
- R5: `cfg_size` selects the active width: 0 means bits 23:0, 1 means bits 47:0 and 2 means bits 127:0. Stored and received bits above the active width have no effect on the verdict. Code 3 makes every checked frame fail.
- R6: With checking enabled, `cfg_even_only` makes a frame whose PN bit 0 is 1 fail, and `cfg_odd_only` makes a frame whose PN bit 0 is 0 fail. With both set, every checked frame fails.
- R7: The stored PN changes only through a passing frame or a software preload. A failing or bypassed frame leaves `pn_stored` and `pn_valid` unchanged.
- R8: A failing frame sets `err_sticky` when `cfg_err_handle_en` is 1. The flag is left unchanged when `cfg_err_handle_en` is 0. Once set, it stays set until `sw_clr_err` is pulsed.
- R9: While `err_sticky` is 1, a frame produces `res_bypass` with neither pass nor fail, and it neither stores its PN nor sets `pn_valid`.
- R10: A `sw_preload` pulse loads `sw_pn` into `pn_stored` and sets `pn_valid` on the next cycle. The preload takes priority over a frame that passes in the same cycle.
- R11: The verdict for a frame strobed in cycle t appears in cycle t+1. Exactly one of pass, fail and bypass is high when `res_valid` is 1. `res_valid` is 0 in a cycle that follows no strobe.
- R12: When `sw_clr_err` arrives in the same cycle as a failing frame that has handling enabled, `err_sticky` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Frame strobe, one cycle per frame |
| frm_pn | input | 128 | Packet number of the frame |
| cfg_check_en | input | 1 | Enables the increment and parity check |
| cfg_even_only | input | 1 | Requires an even PN |
| cfg_odd_only | input | 1 | Requires an odd PN |
| cfg_err_handle_en | input | 1 | Lets a failure set the sticky error flag |
| cfg_size | input | 2 | Active width: 0 for 24 bits, 1 for 48 bits, 2 for 128 bits, 3 illegal |
| sw_clr_err | input | 1 | Software clear of the sticky error flag |
| sw_preload | input | 1 | Software load of the stored PN |
| sw_pn | input | 128 | PN value written by `sw_preload` |
| res_valid | output | 1 | Verdict is valid this cycle |
| res_pass | output | 1 | Frame accepted |
| res_fail | output | 1 | Frame rejected as a replay or on parity |
| res_bypass | output | 1 | Frame sent to the exception path |
| err_sticky | output | 1 | Sticky error flag |
| pn_valid | output | 1 | Stored PN is valid |
| pn_stored | output | 128 | Last accepted or preloaded PN |

## Verification
The assertions check on every cycle that a verdict is one-hot and that a rejected frame leaves the stored PN untouched. They also check that a held error flag persists until software clears it, that any frame arriving under a held flag is bypassed, and that a full-width pass raises the stored PN. The bench scenarios cover what depends on chosen operands. That includes masking of the upper bits at the narrow widths, the illegal size code and the parity rules. It also includes first-frame learning under a check that would otherwise fail, the collision of a clear with a new failure, and a preload racing a passing frame.

// File: rtl/pn_replay_guard.sv
module pn_replay_guard #(
  parameter int PN_W     = 128,
  parameter int NARROW_W = 24,
  parameter int MID_W    = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frm_valid,
  input  logic [PN_W-1:0] frm_pn,
  input  logic            cfg_check_en,
  input  logic            cfg_even_only,
  input  logic            cfg_odd_only,
  input  logic            cfg_err_handle_en,
  input  logic [1:0]      cfg_size,
  input  logic            sw_clr_err,
  input  logic            sw_preload,
  input  logic [PN_W-1:0] sw_pn,
  output logic            res_valid,
  output logic            res_pass,
  output logic            res_fail,
  output logic            res_bypass,
  output logic            err_sticky,
  output logic            pn_valid,
  output logic [PN_W-1:0] pn_stored
);

  localparam logic [PN_W-1:0] MASK_NARROW = {{(PN_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [PN_W-1:0] MASK_MID    = {{(PN_W-MID_W){1'b0}}, {MID_W{1'b1}}};
  localparam logic [PN_W-1:0] MASK_FULL   = {PN_W{1'b1}};

  logic [PN_W-1:0] cmp_mask;
  logic            size_ok, newer, parity_bad, chk_bad;
  logic            fail_now, pass_now, bypass_now;

  always_comb begin
    case (cfg_size)
      2'd0:    cmp_mask = MASK_NARROW;
      2'd1:    cmp_mask = MASK_MID;
      2'd2:    cmp_mask = MASK_FULL;
      default: cmp_mask = '0;
    endcase
  end

  assign size_ok    = (cfg_size != 2'd3);
  assign newer      = (frm_pn & cmp_mask) > (pn_stored & cmp_mask);
  assign parity_bad = (cfg_even_only & frm_pn[0]) | (cfg_odd_only & ~frm_pn[0]);
  assign chk_bad    = cfg_check_en & (~size_ok | ~newer | parity_bad);

  assign bypass_now = frm_valid & err_sticky;
  assign fail_now   = frm_valid & ~err_sticky & pn_valid & chk_bad;
  assign pass_now   = frm_valid & ~err_sticky & ~fail_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pn_stored <= '0;
      pn_valid  <= 1'b0;
    end else if (sw_preload) begin
      pn_stored <= sw_pn;
      pn_valid  <= 1'b1;
    end else if (pass_now) begin
      pn_stored <= frm_pn;
      pn_valid  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             err_sticky <= 1'b0;
    else if (fail_now && cfg_err_handle_en) err_sticky <= 1'b1;
    else if (sw_clr_err)                    err_sticky <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_pass   <= 1'b0;
      res_fail   <= 1'b0;
      res_bypass <= 1'b0;
    end else begin
      res_valid  <= frm_valid;
      res_pass   <= pass_now;
      res_fail   <= fail_now;
      res_bypass <= bypass_now;
    end
  end

  // R11: a verdict carries exactly one outcome
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_pass, res_fail, res_bypass}));

  // R11: no outcome without a verdict
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_pass || res_fail || res_bypass));

  // R7: a rejected frame keeps the stored PN
  a_r7_fail_keeps_pn: assert property (@(posedge clk) disable iff (!rst_n)
    (res_fail && !$past(sw_preload)) |-> (pn_stored == $past(pn_stored)));

  // R8: held flag persists without a clear
  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !sw_clr_err) |=> err_sticky);

  // R9: a frame under a held flag is bypassed
  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && err_sticky) |=> (res_bypass && $stable(pn_valid)));

  // R4: full-width checked pass raises the stored PN
  a_r4_increase: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !err_sticky && pn_valid && cfg_check_en && cfg_size == 2'd2 && !sw_preload)
      |=> (res_fail || pn_stored > $past(pn_stored)));

endmodule

// File: tb/pn_replay_guard_tb_top.sv
`timescale 1ns/1ps
module pn_replay_guard_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frm_valid = 1'b0;
  logic [127:0] frm_pn = '0;
  logic         cfg_check_en = 1'b0, cfg_even_only = 1'b0, cfg_odd_only = 1'b0;
  logic         cfg_err_handle_en = 1'b0;
  logic [1:0]   cfg_size = 2'd2;
  logic         sw_clr_err = 1'b0, sw_preload = 1'b0;
  logic [127:0] sw_pn = '0;
  logic         res_valid, res_pass, res_fail, res_bypass, err_sticky, pn_valid;
  logic [127:0] pn_stored;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [127:0] m_pn = '0;
  logic         m_valid = 1'b0;
  logic         m_err = 1'b0;

  always #2.5 clk = ~clk;

  pn_replay_guard dut_i (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_pn(frm_pn),
    .cfg_check_en(cfg_check_en), .cfg_even_only(cfg_even_only), .cfg_odd_only(cfg_odd_only),
    .cfg_err_handle_en(cfg_err_handle_en), .cfg_size(cfg_size),
    .sw_clr_err(sw_clr_err), .sw_preload(sw_preload), .sw_pn(sw_pn),
    .res_valid(res_valid), .res_pass(res_pass), .res_fail(res_fail), .res_bypass(res_bypass),
    .err_sticky(err_sticky), .pn_valid(pn_valid), .pn_stored(pn_stored));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // outcome code: 0 pass, 1 fail, 2 bypass
  function automatic int exp_kind(input logic [127:0] pn);
    logic [127:0] m;
    if (m_err) return 2;
    if (!m_valid || !cfg_check_en) return 0;
    if (cfg_size == 2'd3) return 1;
    m = (cfg_size == 2'd0) ? {104'd0, {24{1'b1}}} :
        (cfg_size == 2'd1) ? {80'd0, {48{1'b1}}} : {128{1'b1}};
    if ((pn & m) <= (m_pn & m)) return 1;
    if (cfg_even_only && pn[0]) return 1;
    if (cfg_odd_only && !pn[0]) return 1;
    return 0;
  endfunction

  task automatic step(input bit fv, input logic [127:0] pn, input bit clr,
                      input bit pl, input logic [127:0] plpn, input string tag);
    int k;
    logic [2:0] ev;
    k = fv ? exp_kind(pn) : -1;
    ev = (k == 0) ? 3'b100 : (k == 1) ? 3'b010 : (k == 2) ? 3'b001 : 3'b000;
    frm_valid = fv; frm_pn = pn; sw_clr_err = clr; sw_preload = pl; sw_pn = plpn;
    if (pl) begin m_pn = plpn; m_valid = 1'b1; end
    else if (k == 0) begin m_pn = pn; m_valid = 1'b1; end
    if (k == 1 && cfg_err_handle_en) m_err = 1'b1;
    else if (clr) m_err = 1'b0;
    @(negedge clk);
    chk(res_valid == fv, {tag, " R11 res_valid"}, 128'(res_valid), 128'(fv));
    chk({res_pass, res_fail, res_bypass} == ev, {tag, " R11 outcome"},
        128'({res_pass, res_fail, res_bypass}), 128'(ev));
    chk(pn_stored == m_pn, {tag, " R7 pn_stored"}, pn_stored, m_pn);
    chk(pn_valid == m_valid, {tag, " R7 pn_valid"}, 128'(pn_valid), 128'(m_valid));
    chk(err_sticky == m_err, {tag, " R8 err_sticky"}, 128'(err_sticky), 128'(m_err));
    frm_valid = 1'b0; sw_clr_err = 1'b0; sw_preload = 1'b0;
  endtask

  task automatic cfg(input bit c, input bit e, input bit o, input bit h, input logic [1:0] s);
    cfg_check_en = c; cfg_even_only = e; cfg_odd_only = o; cfg_err_handle_en = h; cfg_size = s;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [127:0] pn;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({res_valid, res_pass, res_fail, res_bypass, err_sticky, pn_valid} == 6'b0,
        "R1 reset flags", 128'({res_valid, res_pass, res_fail, res_bypass, err_sticky, pn_valid}), 128'(0));
    chk(pn_stored == '0, "R1 reset pn", pn_stored, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 learn an odd PN while even-only and checking are set
    cfg(1, 1, 0, 0, 2'd2);
    step(1, 128'h1000_0005, 0, 0, '0, "R2 learn");
    // R4 equal PN fails, handling off leaves flag clear (R8)
    cfg(1, 0, 0, 0, 2'd2);
    step(1, 128'h1000_0005, 0, 0, '0, "R4 equal");
    step(1, 128'h1000_0004, 0, 0, '0, "R4 smaller");
    step(1, 128'h1000_0006, 0, 0, '0, "R4 greater");
    // R11 idle cycle
    step(0, '0, 0, 0, '0, "R11 idle");
    // R3 check disabled: smaller PN passes and is stored
    cfg(0, 1, 1, 1, 2'd3);
    step(1, 128'h7, 0, 0, '0, "R3 unchecked");
    // R5 narrow width ignores upper stored bits
    step(0, '0, 0, 1, {104'hFFFF, 24'h000010}, "R10 preload");
    cfg(1, 0, 0, 1, 2'd0);
    step(1, 128'h11, 0, 0, '0, "R5 narrow pass");
    step(1, {8'hFF, 96'd0, 24'h000011}, 0, 0, '0, "R5 narrow upper ignored");
    cfg(1, 0, 0, 0, 2'd1);
    step(1, {80'd0, 48'h8000_0000_0000}, 0, 0, '0, "R5 mid bit47");
    step(1, {1'b1, 79'd0, 48'h0}, 0, 0, '0, "R5 mid upper ignored");
    cfg(1, 0, 0, 0, 2'd3);
    step(1, 128'hFFFF_FFFF, 0, 0, '0, "R5 illegal size");
    // R6 parity
    cfg(1, 1, 0, 0, 2'd2);
    pn = m_pn + 1; if (!pn[0]) pn = pn + 1;
    step(1, pn, 0, 0, '0, "R6 even-only odd");
    step(1, pn + 1, 0, 0, '0, "R6 even-only even");
    cfg(1, 0, 1, 0, 2'd2);
    step(1, m_pn + 2, 0, 0, '0, "R6 odd-only even");
    step(1, m_pn + 1, 0, 0, '0, "R6 odd-only odd");
    cfg(1, 1, 1, 0, 2'd2);
    step(1, m_pn + 1, 0, 0, '0, "R6 both set");
    step(1, m_pn + 2, 0, 0, '0, "R6 both set");
    // R8 failure with handling sets the flag; R9 bypass follows
    cfg(1, 0, 0, 1, 2'd2);
    step(1, m_pn, 0, 0, '0, "R8 set");
    step(1, m_pn + 9, 0, 0, '0, "R9 bypass good pn");
    step(0, '0, 0, 0, '0, "R8 holds");
    // R12 clear colliding with a new failure (flag first cleared)
    step(0, '0, 1, 0, '0, "R8 clear");
    step(1, m_pn, 1, 0, '0, "R12 clear vs fail");
    step(0, '0, 1, 0, '0, "R8 clear");
    // R10 preload beats a passing frame
    step(1, m_pn + 3, 0, 1, 128'h42, "R10 preload priority");
    step(1, 128'h43, 0, 0, '0, "R10 after preload");

    for (int i = 0; i < 500; i++) begin
      int d;
      bit fv;
      fv = ($urandom_range(99) < 80);
      d = $urandom_range(8) - 3;
      pn = ($urandom_range(9) == 0) ? {$urandom, $urandom, $urandom, $urandom}
                                    : m_pn + {{96{d[31]}}, d};
      cfg($urandom_range(99) < 85, $urandom_range(99) < 15, $urandom_range(99) < 15,
          $urandom_range(99) < 30,
          ($urandom_range(19) == 0) ? 2'd3 : 2'($urandom_range(2)));
      step(fv, pn, $urandom_range(19) == 0, $urandom_range(29) == 0,
           {$urandom, $urandom, $urandom, $urandom} >> $urandom_range(127), "rand R4");
    end
    done = 1;
    finish_run();
  end

endmodule